// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects thirteen level-sensitive interrupt sources, numbered 1 to 13, and presents the most urgent one to a processor as a 3-bit interrupt level and an 8-bit vector. Each source has its own 8-bit control byte. The low five bits of that byte are a combined level-and-priority code, bits [4:2] of the same byte give the level shown to the processor, and bit 7 chooses between an autovector and a vector taken from a programmable vector register. A mask register can block each source on its own. The pending register is sampled from the source pins on every clock and is read-only.

Software programs the block through a simple byte-addressed register port. Writes are synchronous and reads are combinational. The level and vector outputs come straight from the registered state through combinational logic, so any change to pending, mask, control or vector state shows at the outputs right after the clock edge that stored it. A source whose winning code is below 4 is treated as if nothing were pending. The acknowledge cycle and nesting are left to the processor side.

Top module: `irq_prio_ctrl`

## Requirements
- R1: On each clock edge, pending bit i (source i, bit position i) takes the value of input irq_src[i]. Pending reads at address 0x3A, with bit i holding source i and all other bits 0. Writes to 0x3A have no effect.
- R2: A source competes only if its pending bit is 1 and its mask bit is 0. A mask bit of 1 blocks that source.
- R3: Among the competing sources, the one whose control bits [4:0] hold the strictly highest value wins. On a tie, the lowest-numbered source wins.
- R4: If the winning code is below 4, or no source competes, irq_level and irq_vector are both 0.
- R5: While a winner is presented, irq_level equals bits [4:2] of the winner's control byte.
- R6: If bit 7 of the winner's control byte is 1, irq_vector equals 24 plus irq_level.
- R7: If bit 7 is 0, irq_vector is taken from a vector register: source 8 uses the watchdog vector register at 0x42, source 12 the register at 0x44, and source 13 the register at 0x45. Any other source gives 0x0F.
- R8: After reset: mask = 0x3FFE; control bytes of sources 1 to 7 = 4 times the source number; source 8 = 0x1C; sources 9 to 11 = 0x80; sources 12 and 13 = 0x00; all three vector registers = 0x0F; pending = 0.
- R9: The control byte of source i sits at address 0x13+i (0x14 to 0x20) and uses wdata[7:0]. The mask sits at 0x36 and uses wdata[13:1], with bit i belonging to source i. All registers read back what was written. Unmapped addresses read 0, and writes to them change nothing.
- R10: A register write changes irq_level and irq_vector at the clock edge that stores it, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 13 | Source levels, bit i is source i (bits 13:1) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| irq_level | output | 3 | Presented interrupt level, 0 = none |
| irq_vector | output | 8 | Presented vector |

## Verification
The bench sweeps every ordered pair of sources with codes chosen so that ties occur between distant indices. A design that resolved ties toward the higher number, or that used a greater-or-equal compare, would then present the wrong source. Sources left at codes 0 to 3 check the below-4 suppression, which a design that only tested for "any active" would miss by raising level 0 with a nonzero vector. Vector-register routing for sources 8, 12 and 13 is checked against the 0x0F default used by the rest. Writes to the pending address and to unmapped space are checked to leave every register alone. The cycle in which a mask write takes effect is checked on both sides of the edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned BYTE_W = 8;

   // Power-up control byte for a source.
   function automatic logic [BYTE_W-1:0] ctl_reset(input int unsigned src);
      if (src >= 1 && src <= 7) return BYTE_W'(src * 4);
      else if (src == 8)        return 8'h1C;
      else if (src >= 9 && src <= 11) return 8'h80;
      else                      return 8'h00;
   endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC      = 13,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CTL_BASE  = 'h14,
   parameter int unsigned MASK_ADR  = 'h36,
   parameter int unsigned PEND_ADR  = 'h3A,
   parameter int unsigned WVEC_ADR  = 'h42,
   parameter int unsigned AVEC_ADR  = 'h44,
   parameter int unsigned BVEC_ADR  = 'h45,
   parameter logic [7:0]  VEC_RST   = 8'h0F
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NSRC:1]            irq_src,
   input  logic                     reg_we,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic [NSRC:1]            pend_o,
   output logic [NSRC:1]            mask_o,
   output logic [NSRC:1][BYTE_W-1:0] ctl_o,
   output logic [BYTE_W-1:0]        wvec_o,
   output logic [BYTE_W-1:0]        avec_o,
   output logic [BYTE_W-1:0]        bvec_o
);
   localparam logic [NSRC:1] MASK_RST = '1;

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[0], reg_wdata[DATA_W-1:NSRC+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= '0;
         mask_o <= MASK_RST;
         wvec_o <= VEC_RST;
         avec_o <= VEC_RST;
         bvec_o <= VEC_RST;
         for (int i = 1; i <= NSRC; i++) ctl_o[i] <= ctl_reset(i);
      end else begin
         pend_o <= irq_src;
         if (reg_we) begin
            if (reg_addr == ADDR_W'(MASK_ADR)) mask_o <= reg_wdata[NSRC:1];
            if (reg_addr == ADDR_W'(WVEC_ADR)) wvec_o <= reg_wdata[BYTE_W-1:0];
            if (reg_addr == ADDR_W'(AVEC_ADR)) avec_o <= reg_wdata[BYTE_W-1:0];
            if (reg_addr == ADDR_W'(BVEC_ADR)) bvec_o <= reg_wdata[BYTE_W-1:0];
            for (int i = 1; i <= NSRC; i++)
               if (reg_addr == ADDR_W'(CTL_BASE + i - 1)) ctl_o[i] <= reg_wdata[BYTE_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(MASK_ADR)) reg_rdata[NSRC:1] = mask_o;
      if (reg_addr == ADDR_W'(PEND_ADR)) reg_rdata[NSRC:1] = pend_o;
      if (reg_addr == ADDR_W'(WVEC_ADR)) reg_rdata[BYTE_W-1:0] = wvec_o;
      if (reg_addr == ADDR_W'(AVEC_ADR)) reg_rdata[BYTE_W-1:0] = avec_o;
      if (reg_addr == ADDR_W'(BVEC_ADR)) reg_rdata[BYTE_W-1:0] = bvec_o;
      for (int i = 1; i <= NSRC; i++)
         if (reg_addr == ADDR_W'(CTL_BASE + i - 1)) reg_rdata[BYTE_W-1:0] = ctl_o[i];
   end

   // R1: pending mirrors the source pins one edge later
   p_pend_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pend_o == $past(irq_src)));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC     = 13,
   parameter int unsigned CODE_W   = 5,
   parameter int unsigned MIN_CODE = 4,
   localparam int unsigned IDX_W   = $clog2(NSRC + 1)
) (
   input  logic [NSRC:1]             active,
   input  logic [NSRC:1][BYTE_W-1:0] ctl,
   output logic                      hit,
   output logic [IDX_W-1:0]          win_idx
);
   logic [CODE_W-1:0] best;
   logic [IDX_W-1:0]  cand;
   logic              unused_ctl;
   assign unused_ctl = ^ctl;

   // Strict compare keeps the earlier (lower-numbered) source on a tie.
   always_comb begin
      best = '0;
      cand = '0;
      for (int i = 1; i <= NSRC; i++) begin
         if (active[i] && (ctl[i][CODE_W-1:0] > best)) begin
            best = ctl[i][CODE_W-1:0];
            cand = IDX_W'(i);
         end
      end
      hit     = (best >= CODE_W'(MIN_CODE));
      win_idx = hit ? cand : '0;
   end
endmodule

// File: rtl/irqc_vector.sv
module irqc_vector
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC     = 13,
   parameter int unsigned CODE_W   = 5,
   parameter int unsigned LVL_W    = 3,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned AUTO_BASE = 24,
   parameter int unsigned AUTO_BIT = 7,
   parameter int unsigned WDOG_SRC = 8,
   parameter int unsigned ASRC     = 12,
   parameter int unsigned BSRC     = 13,
   parameter logic [7:0]  DFLT_VEC = 8'h0F,
   localparam int unsigned IDX_W   = $clog2(NSRC + 1),
   localparam int unsigned LVL_LSB = CODE_W - LVL_W
) (
   input  logic              hit,
   input  logic [IDX_W-1:0]  win_idx,
   input  logic [BYTE_W-1:0] win_ctl,
   input  logic [BYTE_W-1:0] wvec,
   input  logic [BYTE_W-1:0] avec,
   input  logic [BYTE_W-1:0] bvec,
   output logic [LVL_W-1:0]  level,
   output logic [VEC_W-1:0]  vector
);
   logic unused_ctl;
   assign unused_ctl = ^win_ctl;

   always_comb begin
      level  = '0;
      vector = '0;
      if (hit) begin
         level = win_ctl[CODE_W-1:LVL_LSB];
         if (win_ctl[AUTO_BIT])              vector = VEC_W'(AUTO_BASE) + VEC_W'(level);
         else if (win_idx == IDX_W'(WDOG_SRC)) vector = VEC_W'(wvec);
         else if (win_idx == IDX_W'(ASRC))   vector = VEC_W'(avec);
         else if (win_idx == IDX_W'(BSRC))   vector = VEC_W'(bvec);
         else                                vector = VEC_W'(DFLT_VEC);
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC      = 13,
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned LVL_W     = 3,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned MIN_CODE  = 4,
   parameter int unsigned AUTO_BASE = 24,
   parameter int unsigned WDOG_SRC  = 8,
   parameter int unsigned ASRC      = 12,
   parameter int unsigned BSRC      = 13,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC:1]     irq_src,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [LVL_W-1:0]  irq_level,
   output logic [VEC_W-1:0]  irq_vector
);
   localparam int unsigned IDX_W = $clog2(NSRC + 1);

   if (NSRC < 1 || NSRC + 1 > DATA_W) begin : g_bad_nsrc
      $error("NSRC must fit the data word above bit 0");
   end
   if (CODE_W < LVL_W || CODE_W > BYTE_W - 1) begin : g_bad_code
      $error("code field must hold the level and leave the autovector bit");
   end
   if (MIN_CODE >= (1 << CODE_W)) begin : g_bad_min
      $error("MIN_CODE exceeds the code range");
   end
   if (AUTO_BASE + (1 << LVL_W) > (1 << VEC_W)) begin : g_bad_auto
      $error("autovector range overflows the vector width");
   end
   if (WDOG_SRC > NSRC || ASRC > NSRC || BSRC > NSRC) begin : g_bad_vsrc
      $error("vector-register source out of range");
   end

   logic [NSRC:1]             pend, mask;
   logic [NSRC:1][BYTE_W-1:0] ctl;
   logic [BYTE_W-1:0]         wvec, avec, bvec, win_ctl;
   logic                      hit;
   logic [IDX_W-1:0]          win_idx;

   irqc_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pend_o(pend), .mask_o(mask), .ctl_o(ctl),
      .wvec_o(wvec), .avec_o(avec), .bvec_o(bvec));

   irqc_arbiter #(.NSRC(NSRC), .CODE_W(CODE_W), .MIN_CODE(MIN_CODE)) u_arb (
      .active(pend & ~mask), .ctl(ctl), .hit(hit), .win_idx(win_idx));

   assign win_ctl = hit ? ctl[win_idx] : '0;

   irqc_vector #(.NSRC(NSRC), .CODE_W(CODE_W), .LVL_W(LVL_W), .VEC_W(VEC_W),
      .AUTO_BASE(AUTO_BASE), .WDOG_SRC(WDOG_SRC), .ASRC(ASRC), .BSRC(BSRC)) u_vec (
      .hit(hit), .win_idx(win_idx), .win_ctl(win_ctl),
      .wvec(wvec), .avec(avec), .bvec(bvec),
      .level(irq_level), .vector(irq_vector));

   // R2: a presented source is pending and unmasked
   p_win_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (pend[win_idx] && !mask[win_idx]));
   // R4: a presented winner's code meets the floor
   p_win_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (ctl[win_idx][CODE_W-1:0] >= CODE_W'(MIN_CODE)));
   // R4: idle means level and vector both zero
   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level == '0) |-> (irq_vector == '0));
   // R5: level field of the winner reaches the pins
   p_level_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (irq_level == ctl[win_idx][CODE_W-1:CODE_W-LVL_W]));
   // R6: autovector offset from the base
   p_autovec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctl[win_idx][BYTE_W-1]) |-> (irq_vector == VEC_W'(AUTO_BASE) + VEC_W'(irq_level)));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:1] irq_src = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [2:0]  irq_level;
   logic [7:0]  irq_vector;

   int checks = 0;
   int failures = 0;

   logic [7:0]  ctl_m [1:13];
   logic [13:1] mask_m, src_m;
   logic [7:0]  wv_m, av_m, bv_m;
   logic [31:0] rng = 32'h1234_5679;

   always #4 clk = ~clk;

   irq_prio_ctrl u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_level(irq_level), .irq_vector(irq_vector));

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic logic [10:0] model();
      int best = 0;
      int win = 0;
      logic [2:0] lvl;
      logic [7:0] vec;
      for (int i = 1; i <= 13; i++)
         if (src_m[i] && !mask_m[i] && int'(ctl_m[i][4:0]) > best) begin
            best = int'(ctl_m[i][4:0]);
            win = i;
         end
      if (best < 4) return '0;
      lvl = ctl_m[win][4:2];
      if (ctl_m[win][7]) vec = 8'(24 + lvl);
      else if (win == 8)  vec = wv_m;
      else if (win == 12) vec = av_m;
      else if (win == 13) vec = bv_m;
      else vec = 8'h0F;
      return {lvl, vec};
   endfunction

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a >= 8'h14 && a <= 8'h20) ctl_m[a - 8'h13] = d[7:0];
      if (a == 8'h36) mask_m = d[13:1];
      if (a == 8'h42) wv_m = d[7:0];
      if (a == 8'h44) av_m = d[7:0];
      if (a == 8'h45) bv_m = d[7:0];
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic drive(input logic [13:1] v);
      @(negedge clk);
      irq_src = v; src_m = v;
      @(negedge clk);
   endtask

   task automatic chk_out(input string req);
      chk(req, {5'b0, irq_level, irq_vector}, {5'b0, model()});
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] x);
      logic [31:0] y = x;
      y ^= y << 13; y ^= y >> 17; y ^= y << 5;
      return y;
   endfunction

   initial begin : wdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [15:0] d;
      for (int i = 1; i <= 13; i++)
         ctl_m[i] = (i <= 7) ? 8'(4 * i) : (i == 8) ? 8'h1C : (i <= 11) ? 8'h80 : 8'h00;
      mask_m = '1; src_m = '0; wv_m = 8'h0F; av_m = 8'h0F; bv_m = 8'h0F;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: reset values
      for (int i = 1; i <= 13; i++) begin
         rd(8'(8'h13 + i), d);
         chk("R8 ctl reset", d, {8'h00, ctl_m[i]});
      end
      rd(8'h36, d); chk("R8 mask reset", d, 16'h3FFE);
      rd(8'h42, d); chk("R8 wdog vec reset", d, 16'h000F);
      rd(8'h44, d); chk("R8 vec A reset", d, 16'h000F);
      rd(8'h45, d); chk("R8 vec B reset", d, 16'h000F);
      rd(8'h3A, d); chk("R8 pend reset", d, 16'h0000);
      chk("R8 outputs idle", {5'b0, irq_level, irq_vector}, 16'h0);

      // R2: all masked, sources raised -> nothing
      drive('1);
      chk_out("R2 all masked");
      rd(8'h3A, d); chk("R1 pending readback", d, 16'h3FFE);

      // R1/R9: write to pending and unmapped space ignored
      wr(8'h3A, 16'h0000);
      rd(8'h3A, d); chk("R1 pending write ignored", d, 16'h3FFE);
      wr(8'h50, 16'hFFFF);
      rd(8'h50, d); chk("R9 unmapped reads zero", d, 16'h0000);
      rd(8'h36, d); chk("R9 unmapped write leaves mask", d, 16'h3FFE);
      for (int i = 1; i <= 13; i++) begin
         rd(8'(8'h13 + i), d);
         chk("R9 unmapped write leaves ctl", d, {8'h00, ctl_m[i]});
      end

      // R10: mask write takes effect at its storing edge
      drive(13'h0001 << 0);  // source 1 only
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'h36; reg_wdata = 16'h0000;
      #1 chk("R10 before edge unchanged", {5'b0, irq_level, irq_vector}, 16'h0);
      @(negedge clk);
      reg_we = 1'b0; mask_m = '0;
      chk("R10 after edge source1", {5'b0, irq_level, irq_vector}, {5'b0, 3'd1, 8'h0F});

      // R4/R5/R6/R7: each reset-value source alone
      for (int i = 1; i <= 13; i++) begin
         drive(13'(1) << (i - 1));
         chk_out($sformatf("R4 R5 R6 R7 single source %0d", i));
      end

      // R7: programmed vector registers
      wr(8'h42, 16'h00A5); wr(8'h44, 16'h005A); wr(8'h45, 16'h00C3);
      rd(8'h44, d); chk("R9 vec A readback", d, 16'h005A);

      // R3: every pair, codes repeat with period 5 so ties span sources
      for (int i = 1; i <= 13; i++)
         wr(8'(8'h13 + i), {8'h00, (i % 2 == 1) ? 1'b1 : 1'b0, 2'b00, 5'(4 + (i % 5) * 5)});
      wr(8'h20, 16'h0014);  // source 13 vector-register routed
      rd(8'h20, d); chk("R9 ctl readback", d, 16'h0014);
      for (int a = 1; a <= 13; a++)
         for (int b = 1; b <= 13; b++) begin
            drive((13'(1) << (a - 1)) | (13'(1) << (b - 1)));
            chk_out($sformatf("R3 pair %0d %0d", a, b));
         end

      // R4: codes below floor never present
      for (int i = 1; i <= 13; i++) wr(8'(8'h13 + i), {8'h00, 8'h80 | 8'(i % 4)});
      drive('1);
      chk_out("R4 below floor all active");

      // R2/R3/R5/R6/R7: random state
      for (int n = 0; n < 400; n++) begin
         rng = nxt(rng);
         wr(8'(8'h14 + rng[3:0] % 13), {8'h00, rng[15:8]});
         rng = nxt(rng);
         if (rng[0]) wr(8'h36, rng[31:16]);
         rng = nxt(rng);
         drive(rng[13:1]);
         chk_out("R2 R3 R5 R6 R7 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule